// File: doc/BRIEF.md
# Serial Port Interrupt Request Generator

This block produces the four interrupt requests of an asynchronous serial port: receive error, receive data full, transmit data empty and transmit end. It sits between the port's control register bits and its shift-register datapath. The datapath reports three kinds of event as single-cycle strobes: the transmit buffer has been moved into the shift register, the last stop bit has been sent, and a received byte has been stored. The datapath also supplies the overrun, framing and parity error flags as levels. The register interface supplies strobes for a write to the transmit buffer and a read of the receive buffer.

The transmit side tracks the buffer and the shift register with a four-state machine. `TX_END` is the reset state: the line is idle, the buffer is empty and the transmit-end flag is set. In `TX_FULL` the buffer holds data that waits to be loaded. In `TX_SHIFT` a frame is being shifted and the buffer is empty. In `TX_SHIFT_FULL` a frame is being shifted and the next byte is already buffered. The transitions are as follows. A buffer write moves `TX_END` to `TX_FULL` and `TX_SHIFT` to `TX_SHIFT_FULL`. A load moves `TX_FULL` to `TX_SHIFT`, or to `TX_SHIFT_FULL` when a write arrives in the same cycle. A last-bit strobe moves `TX_SHIFT` to `TX_END` and `TX_SHIFT_FULL` to `TX_FULL`. In `TX_SHIFT`, a write takes priority over a last-bit strobe that arrives in the same cycle.

The transmit-empty and receive-full sources each drive a level request that stays set until it is serviced. Each also drives a one-cycle DMA trigger pulse. The error and transmit-end sources have interrupt levels only.

Top module: `sio_irq_gen`

## Requirements
- R1: After reset, `tx_end_flag` is 1 and every interrupt and DMA output is 0.
- R2: A load strobe while `txe_ie` is 1 sets `irq_txe` and pulses `dma_txe` in the next cycle.
- R3: A 0-to-1 change of `tx_en` while `txe_ie` is 1 raises the transmit-empty request in the next cycle. This holds whether `txe_ie` was already 1 or is set in the same cycle.
- R4: Setting `tx_en` while `txe_ie` is 0 raises no transmit-empty request. Setting `txe_ie` while `tx_en` is already 1 raises no transmit-empty request either.
- R5: A transmit-buffer write, or clearing `txe_ie`, withdraws `irq_txe` in the next cycle.
- R6: A last-bit strobe in `TX_SHIFT` sets `tx_end_flag` in the next cycle. A last-bit strobe in `TX_SHIFT_FULL` leaves the flag at 0.
- R7: `irq_tend` equals `tx_end_flag & tend_ie & tx_en` in the same cycle. Setting `tend_ie` while the flag is 1 therefore raises the request at once.
- R8: A transmit-buffer write clears `tx_end_flag`, and with it `irq_tend`, in the next cycle.
- R9: A store strobe while `rx_ie` is 1 and all error flags are 0 sets `irq_rxf` and pulses `dma_rxf` in the next cycle. A receive-buffer read clears `irq_rxf` in the next cycle.
- R10: A store strobe that arrives while any error flag (bit 0 overrun, bit 1 framing, bit 2 parity) is 1 raises no receive-full request.
- R11: `irq_rxerr` is 1 in the cycle after any cycle in which `rx_ie` is 1 and any error flag is 1. It falls only after all error flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_en | input | 1 | Transmitter enable bit |
| txe_ie | input | 1 | Transmit-empty interrupt enable |
| tend_ie | input | 1 | Transmit-end interrupt enable |
| rx_ie | input | 1 | Receive and error interrupt enable |
| tdb_wr | input | 1 | Transmit-buffer write strobe |
| tdb_load | input | 1 | Strobe: buffer moved into the shift register |
| tx_last | input | 1 | Strobe: last stop bit sent |
| rx_store | input | 1 | Strobe: received byte stored |
| rdb_rd | input | 1 | Receive-buffer read strobe |
| rx_err | input | ERR_W | Error flags: bit 0 overrun, bit 1 framing, bit 2 parity |
| tx_end_flag | output | 1 | Transmit-end status flag |
| irq_txe | output | 1 | Transmit-empty interrupt level |
| irq_tend | output | 1 | Transmit-end interrupt level |
| irq_rxf | output | 1 | Receive-full interrupt level |
| irq_rxerr | output | 1 | Receive-error interrupt level |
| dma_txe | output | 1 | Transmit-empty DMA trigger pulse |
| dma_rxf | output | 1 | Receive-full DMA trigger pulse |

## Verification
The bench builds the block with its default of three error flags. This keeps all eight error patterns, each crossed with both settings of the receive enable, small enough to sweep in full. The same small setting allows all sixteen before-and-after combinations of transmitter enable and transmit-empty enable to be applied. Each expected result is computed by formula. A directed walk through all four transmit states covers both outcomes of the last-bit strobe.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;
    typedef enum logic [1:0] {
        TX_END        = 2'd0,
        TX_FULL       = 2'd1,
        TX_SHIFT      = 2'd2,
        TX_SHIFT_FULL = 2'd3
    } tx_state_e;
endpackage

// File: rtl/sio_tx_track.sv
module sio_tx_track
    import sio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tdb_wr,
    input  logic tdb_load,
    input  logic tx_last,
    output logic tend_flag
);
    tx_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_END;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_END: begin
                if (tdb_wr) state_d = TX_FULL;
            end
            TX_FULL: begin
                if (tdb_load) state_d = tdb_wr ? TX_SHIFT_FULL : TX_SHIFT;
            end
            TX_SHIFT: begin
                if (tdb_wr)       state_d = TX_SHIFT_FULL;
                else if (tx_last) state_d = TX_END;
            end
            TX_SHIFT_FULL: begin
                if (tx_last) state_d = TX_FULL;
            end
            default: state_d = TX_END;
        endcase
    end

    always_comb begin
        tend_flag = (state_q == TX_END);
    end

    // R6: last bit with an empty buffer ends transmission
    p_tend_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_SHIFT && tx_last && !tdb_wr) |=> tend_flag);
    // R6: last bit with a buffered byte keeps the flag low
    p_tend_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_SHIFT_FULL) |=> !tend_flag);
    // R8: a buffer write clears the flag
    p_wr_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tdb_wr |=> !tend_flag);
endmodule

// File: rtl/sio_txe_req.sv
module sio_txe_req (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic txe_ie,
    input  logic tdb_wr,
    input  logic tdb_load,
    output logic irq_txe,
    output logic dma_txe
);
    logic en_q;
    logic pend_q;
    logic fire;

    always_comb begin
        fire = txe_ie && (tdb_load || (tx_en && !en_q));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            pend_q  <= 1'b0;
            dma_txe <= 1'b0;
        end else begin
            en_q    <= tx_en;
            dma_txe <= fire;
            if (fire)                     pend_q <= 1'b1;
            else if (tdb_wr || !txe_ie)   pend_q <= 1'b0;
        end
    end

    always_comb begin
        irq_txe = pend_q;
    end

    // R2: load with enable raises request and DMA trigger
    p_load_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tdb_load && txe_ie) |=> (irq_txe && dma_txe));
    // R4: no trigger without a load or an enable rise
    p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tdb_load && !(tx_en && !en_q)) |=> !dma_txe);
    // R5: servicing withdraws the request
    p_service_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tdb_wr && !tdb_load && !(tx_en && !en_q)) |=> !irq_txe);
endmodule

// File: rtl/sio_rx_req.sv
module sio_rx_req #(
    parameter int ERR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_ie,
    input  logic             rx_store,
    input  logic             rdb_rd,
    input  logic [ERR_W-1:0] rx_err,
    output logic             irq_rxf,
    output logic             irq_rxerr,
    output logic             dma_rxf
);
    logic err_any;
    logic fire;
    logic pend_q;

    always_comb begin
        err_any = |rx_err;
        fire    = rx_store && rx_ie && !err_any;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q    <= 1'b0;
            dma_rxf   <= 1'b0;
            irq_rxerr <= 1'b0;
        end else begin
            dma_rxf   <= fire;
            irq_rxerr <= rx_ie && err_any;
            if (fire)                   pend_q <= 1'b1;
            else if (rdb_rd || !rx_ie)  pend_q <= 1'b0;
        end
    end

    always_comb begin
        irq_rxf = pend_q;
    end

    // R9: clean store raises receive-full
    p_rxf_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_store && rx_ie && !err_any) |=> (irq_rxf && dma_rxf));
    // R10: an error masks the receive-full trigger
    p_err_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_store && err_any) |=> !dma_rxf);
    // R11: error request follows the flags
    p_rxerr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ie && err_any) |=> irq_rxerr);
endmodule

// File: rtl/sio_irq_gen.sv
module sio_irq_gen #(
    parameter int ERR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             txe_ie,
    input  logic             tend_ie,
    input  logic             rx_ie,
    input  logic             tdb_wr,
    input  logic             tdb_load,
    input  logic             tx_last,
    input  logic             rx_store,
    input  logic             rdb_rd,
    input  logic [ERR_W-1:0] rx_err,
    output logic             tx_end_flag,
    output logic             irq_txe,
    output logic             irq_tend,
    output logic             irq_rxf,
    output logic             irq_rxerr,
    output logic             dma_txe,
    output logic             dma_rxf
);
    sio_tx_track u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .tdb_wr    (tdb_wr),
        .tdb_load  (tdb_load),
        .tx_last   (tx_last),
        .tend_flag (tx_end_flag)
    );

    sio_txe_req u_txe (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_en    (tx_en),
        .txe_ie   (txe_ie),
        .tdb_wr   (tdb_wr),
        .tdb_load (tdb_load),
        .irq_txe  (irq_txe),
        .dma_txe  (dma_txe)
    );

    sio_rx_req #(.ERR_W(ERR_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_ie     (rx_ie),
        .rx_store  (rx_store),
        .rdb_rd    (rdb_rd),
        .rx_err    (rx_err),
        .irq_rxf   (irq_rxf),
        .irq_rxerr (irq_rxerr),
        .dma_rxf   (dma_rxf)
    );

    always_comb begin
        irq_tend = tx_end_flag && tend_ie && tx_en;
    end

    // R7: setting the enable while the flag is set raises the request at once
    p_tend_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_end_flag && tx_en && !tdb_wr && !tdb_load && !tx_last && $rose(tend_ie)) |-> irq_tend);
endmodule

// File: tb/sio_irq_gen_test.sv
module sio_irq_gen_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_en = 0, txe_ie = 0, tend_ie = 0, rx_ie = 0;
    logic tdb_wr = 0, tdb_load = 0, tx_last = 0, rx_store = 0, rdb_rd = 0;
    logic [2:0] rx_err = '0;
    logic tx_end_flag, irq_txe, irq_tend, irq_rxf, irq_rxerr, dma_txe, dma_rxf;
    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sio_irq_gen uut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .txe_ie(txe_ie), .tend_ie(tend_ie),
        .rx_ie(rx_ie), .tdb_wr(tdb_wr), .tdb_load(tdb_load), .tx_last(tx_last),
        .rx_store(rx_store), .rdb_rd(rdb_rd), .rx_err(rx_err),
        .tx_end_flag(tx_end_flag), .irq_txe(irq_txe), .irq_tend(irq_tend),
        .irq_rxf(irq_rxf), .irq_rxerr(irq_rxerr), .dma_txe(dma_txe), .dma_rxf(dma_rxf)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // advance one edge; inputs are driven and outputs sampled at the falling edge
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        cyc(); cyc();
        // R1 reset state
        chk("R1 tend", tx_end_flag, 1'b1);
        chk("R1 txe", irq_txe, 1'b0);
        chk("R1 rxf", irq_rxf, 1'b0);
        chk("R1 rxerr", irq_rxerr, 1'b0);
        chk("R1 dma", dma_txe | dma_rxf, 1'b0);
        rst_n = 1'b1;
        cyc();

        // R3 / R4 sweep over enable orderings
        for (int k = 0; k < 16; k++) begin
            logic pe, pi, ne, ni, exp_fire, exp_lvl;
            pe = k[3]; pi = k[2]; ne = k[1]; ni = k[0];
            tx_en = 0; txe_ie = 0;
            cyc(); cyc();
            tx_en = pe; txe_ie = pi;
            cyc();
            tx_en = ne; txe_ie = ni;
            cyc();
            exp_fire = ne & ~pe & ni;
            exp_lvl  = ni & ((pe & pi) | exp_fire);
            chk("R3/R4 dma_txe", dma_txe, exp_fire);
            chk("R3/R4 irq_txe", irq_txe, exp_lvl);
        end

        // transmit walk: tend flag and txe servicing
        tx_en = 1; txe_ie = 1; tend_ie = 1;
        cyc();
        chk("R7 irq_tend", irq_tend, 1'b1);
        tend_ie = 0;
        #1 chk("R7 tend masked", irq_tend, 1'b0);
        tend_ie = 1;
        #1 chk("R7 tend reenabled", irq_tend, 1'b1);
        tdb_wr = 1; cyc(); tdb_wr = 0;
        chk("R8 flag cleared", tx_end_flag, 1'b0);
        chk("R8 irq_tend", irq_tend, 1'b0);
        chk("R5 txe withdrawn", irq_txe, 1'b0);
        tdb_load = 1; cyc(); tdb_load = 0;
        chk("R2 irq_txe", irq_txe, 1'b1);
        chk("R2 dma_txe", dma_txe, 1'b1);
        cyc();
        chk("R2 dma single pulse", dma_txe, 1'b0);
        chk("R2 level held", irq_txe, 1'b1);
        tdb_wr = 1; cyc(); tdb_wr = 0;
        chk("R5 write service", irq_txe, 1'b0);
        tx_last = 1; cyc(); tx_last = 0;
        chk("R6 buffered stays low", tx_end_flag, 1'b0);
        tdb_load = 1; cyc(); tdb_load = 0;
        chk("R2 second load", irq_txe, 1'b1);
        txe_ie = 0; cyc();
        chk("R5 enable clear", irq_txe, 1'b0);
        tx_last = 1; cyc(); tx_last = 0;
        chk("R6 flag set", tx_end_flag, 1'b1);
        chk("R7 irq_tend raised", irq_tend, 1'b1);
        tx_en = 0;
        #1 chk("R7 tx off masks", irq_tend, 1'b0);
        chk("R4 no dma with ie off", dma_txe, 1'b0);

        // R9 / R10 / R11 receive sweep
        for (int e = 0; e < 8; e++) begin
            for (int ie = 0; ie < 2; ie++) begin
                logic exp_ok, exp_err;
                rx_ie = ie[0]; rx_err = 3'(e);
                rx_store = 1; cyc(); rx_store = 0;
                exp_ok  = ie[0] & (e == 0);
                exp_err = ie[0] & (e != 0);
                chk("R9/R10 dma_rxf", dma_rxf, exp_ok);
                chk("R9/R10 irq_rxf", irq_rxf, exp_ok);
                chk("R11 irq_rxerr", irq_rxerr, exp_err);
                rx_err = '0; rdb_rd = 1; cyc(); rdb_rd = 0;
                chk("R9 read clears", irq_rxf, 1'b0);
                chk("R11 cleared", irq_rxerr, 1'b0);
            end
        end

        // R11 partial clearing keeps request
        rx_ie = 1; rx_err = 3'b011; cyc();
        chk("R11 raised", irq_rxerr, 1'b1);
        rx_err = 3'b010; cyc();
        chk("R11 held one flag", irq_rxerr, 1'b1);
        rx_err = 3'b000; cyc();
        chk("R11 withdrawn", irq_rxerr, 1'b0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule